// File: doc/BRIEF.md
# BCD Minutes-Seconds Countdown Chain

This block holds a four-digit time value in BCD (minute tens, minute units, second tens, second units) and counts it down by one second for each tick enable. A borrow ripples from the seconds field into the minutes field. The second tens digit wraps from 0 to 5, so the seconds field runs 59 down to 00 and then starts again at 59. The minute digits wrap through 9, so a full underflow from 00:00 gives 99:59.

Two level inputs steer the chain from outside. A load input copies a two-digit BCD minute preset into the minute digits. While load is held the display shows the preset, and ticks cannot move the minutes. A clear input forces the seconds to 00 and blocks their borrow. The block provides no tick generation, no display decoding and no run/stop sequencing. The tick arrives as a one-cycle enable on the single system clock. A run controller normally holds load and clear while stopped and releases both to start.

Top module: `bcd_countdown_chain`

## Requirements
- R1: On a tick, with clear low, the second units digit decrements. From 0 it becomes 9 and raises a borrow into the second tens digit.
- R2: The second tens digit decrements only on a borrow from the second units digit. From 0 it becomes 5, so the seconds field steps from 00 to 59, and it never holds a value above 5.
- R3: With load low, the minute units digit changes only on a tick that finds the seconds at 00 with clear low. There it decrements, and from 0 it becomes 9.
- R4: The minute tens digit decrements when the minute units digit borrows. A tick at 00:00 with load and clear low gives 99:59.
- R5: While load is high, the minute digits take the preset on every clock edge, whatever the tick does. The seconds keep counting.
- R6: While clear is high, both seconds digits are 00 after each edge, and no borrow reaches the minutes.
- R7: isZero is high exactly when all four digits are 0.
- R8: An edge with tick, load and clear all low changes no digit.
- R9: A synchronous reset (rst high at an edge) sets all digits to 0, and it overrides every other input.
- R10: A preset digit above 9 is loaded as 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-cycle tick enable, one per second |
| loadMin | input | 1 | Level: copy preset into minute digits |
| clearSec | input | 1 | Level: force seconds to 00 |
| presetTens | input | 4 | BCD preset, minute tens |
| presetUnits | input | 4 | BCD preset, minute units |
| minTens | output | 4 | Minute tens digit |
| minUnits | output | 4 | Minute units digit |
| secTens | output | 4 | Second tens digit |
| secUnits | output | 4 | Second units digit |
| isZero | output | 1 | High when all digits are 0 |

## Verification
The digits are outputs, so a wrong wrap value or a misplaced borrow shows on the ports at the edge that follows the faulty tick. The one exception is a bad minute borrow. It shows only when the seconds field passes 00, which takes up to 60 ticks. For this reason the bench runs the seconds field through a full 58-tick descent, and it also forces the 00 boundary at once through clear. A wrong priority between load or clear and the tick shows in the same cycle, in the held digits.

// File: rtl/bcd_cd_pkg.sv
package bcd_cd_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 4;
  localparam int IDX_SU = 0;
  localparam int IDX_ST = 1;
  localparam int IDX_MU = 2;
  localparam int IDX_MT = 3;

  typedef struct packed {
    logic [NUM_DIGITS-1:0] dec;
    logic                  loadMin;
    logic                  clearSec;
  } cd_strobe_t;
endpackage

// File: rtl/bcd_cd_digit.sv
module bcd_cd_digit #(
  parameter int W   = 4,
  parameter int MAX = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dec,
  input  logic         load,
  input  logic         clr,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] val,
  output logic         atZero
);
  localparam logic [W-1:0] WRAP_VAL = W'(MAX);

  always_ff @(posedge clk) begin
    if (rst || clr)  val <= '0;
    else if (load)   val <= loadVal;
    else if (dec)    val <= (val == '0) ? WRAP_VAL : val - 1'b1;
  end

  assign atZero = (val == '0);
endmodule

// File: rtl/bcd_cd_ctrl.sv
module bcd_cd_ctrl
  import bcd_cd_pkg::*;
(
  input  logic                  tickEn,
  input  logic                  loadMin,
  input  logic                  clearSec,
  input  logic [NUM_DIGITS-1:0] atZero,
  output cd_strobe_t            strobe,
  output logic                  allZero
);
  logic decSu, decSt, decMu, decMt;

  // borrow ripple: each stage decrements when the one below is at zero
  assign decSu = tickEn & ~clearSec;
  assign decSt = decSu & atZero[IDX_SU];
  assign decMu = decSt & atZero[IDX_ST] & ~loadMin;
  assign decMt = decMu & atZero[IDX_MU];

  always_comb begin
    strobe             = '0;
    strobe.dec[IDX_SU] = decSu;
    strobe.dec[IDX_ST] = decSt;
    strobe.dec[IDX_MU] = decMu;
    strobe.dec[IDX_MT] = decMt;
    strobe.loadMin     = loadMin;
    strobe.clearSec    = clearSec;
  end

  assign allZero = &atZero;
endmodule

// File: rtl/bcd_cd_datapath.sv
module bcd_cd_datapath
  import bcd_cd_pkg::*;
#(
  parameter int SEC_TENS_MAX = 5,
  parameter int DIGIT_MAX    = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  cd_strobe_t            strobe,
  input  logic [DIGIT_W-1:0]    presetTens,
  input  logic [DIGIT_W-1:0]    presetUnits,
  output logic [DIGIT_W-1:0]    digit [NUM_DIGITS],
  output logic [NUM_DIGITS-1:0] atZero
);
  localparam logic [DIGIT_W-1:0] CLAMP_VAL = DIGIT_W'(DIGIT_MAX);

  function automatic logic [DIGIT_W-1:0] clampDigit(input logic [DIGIT_W-1:0] d);
    return (d > CLAMP_VAL) ? CLAMP_VAL : d;
  endfunction

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    localparam int  MAXV   = (i == IDX_ST) ? SEC_TENS_MAX : DIGIT_MAX;
    localparam bit  IS_MIN = (i >= IDX_MU);
    logic [DIGIT_W-1:0] loadVal;

    if (i == IDX_MT)      begin : g_lt assign loadVal = clampDigit(presetTens);  end
    else if (i == IDX_MU) begin : g_lu assign loadVal = clampDigit(presetUnits); end
    else                  begin : g_l0 assign loadVal = '0;                      end

    bcd_cd_digit #(.W(DIGIT_W), .MAX(MAXV)) u_digit (
      .clk     (clk),
      .rst     (rst),
      .dec     (strobe.dec[i]),
      .load    (IS_MIN ? strobe.loadMin : 1'b0),
      .clr     (IS_MIN ? 1'b0 : strobe.clearSec),
      .loadVal (loadVal),
      .val     (digit[i]),
      .atZero  (atZero[i])
    );
  end
endmodule

// File: rtl/bcd_countdown_chain.sv
module bcd_countdown_chain
  import bcd_cd_pkg::*;
#(
  parameter int SEC_TENS_MAX = 5,
  parameter int DIGIT_MAX    = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tickEn,
  input  logic               loadMin,
  input  logic               clearSec,
  input  logic [DIGIT_W-1:0] presetTens,
  input  logic [DIGIT_W-1:0] presetUnits,
  output logic [DIGIT_W-1:0] minTens,
  output logic [DIGIT_W-1:0] minUnits,
  output logic [DIGIT_W-1:0] secTens,
  output logic [DIGIT_W-1:0] secUnits,
  output logic               isZero
);
  cd_strobe_t            strobe;
  logic [NUM_DIGITS-1:0] atZero;
  logic [DIGIT_W-1:0]    digit [NUM_DIGITS];

  bcd_cd_ctrl u_ctrl (
    .tickEn   (tickEn),
    .loadMin  (loadMin),
    .clearSec (clearSec),
    .atZero   (atZero),
    .strobe   (strobe),
    .allZero  (isZero)
  );

  bcd_cd_datapath #(.SEC_TENS_MAX(SEC_TENS_MAX), .DIGIT_MAX(DIGIT_MAX)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .presetTens  (presetTens),
    .presetUnits (presetUnits),
    .digit       (digit),
    .atZero      (atZero)
  );

  assign secUnits = digit[IDX_SU];
  assign secTens  = digit[IDX_ST];
  assign minUnits = digit[IDX_MU];
  assign minTens  = digit[IDX_MT];
endmodule

// File: rtl/bcd_countdown_chain_chk.sv
module bcd_countdown_chain_chk (
  input logic       clk,
  input logic       rst,
  input logic       tickEn,
  input logic       loadMin,
  input logic       clearSec,
  input logic [3:0] presetTens,
  input logic [3:0] presetUnits,
  input logic [3:0] minTens,
  input logic [3:0] minUnits,
  input logic [3:0] secTens,
  input logic [3:0] secUnits,
  input logic       isZero
);
  p_unit_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tickEn) && !$past(clearSec) && $past(secUnits) == 4'd0)
      |-> secUnits == 4'd9);

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tickEn) && !$past(clearSec) &&
     $past(secUnits) == 4'd0 && $past(secTens) == 4'd0)
      |-> (secTens == 4'd5 && secUnits == 4'd9));

  p_sec_tens_range_r2: assert property (@(posedge clk) disable iff (rst)
    secTens <= 4'd5);

  p_min_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(loadMin) &&
     !($past(tickEn) && !$past(clearSec) && $past(secTens) == 4'd0 && $past(secUnits) == 4'd0))
      |-> minUnits == $past(minUnits));

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(loadMin))
      |-> (minUnits == (($past(presetUnits) > 4'd9) ? 4'd9 : $past(presetUnits)) &&
           minTens  == (($past(presetTens)  > 4'd9) ? 4'd9 : $past(presetTens))));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clearSec)) |-> (secTens == 4'd0 && secUnits == 4'd0));

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tickEn) && !$past(loadMin) && !$past(clearSec))
      |-> ($stable(minTens) && $stable(minUnits) && $stable(secTens) && $stable(secUnits)));

  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (minTens == 4'd0 && minUnits == 4'd0 &&
                    secTens == 4'd0 && secUnits == 4'd0 && isZero));
endmodule

bind bcd_countdown_chain bcd_countdown_chain_chk u_chk (
  .clk(clk), .rst(rst), .tickEn(tickEn), .loadMin(loadMin), .clearSec(clearSec),
  .presetTens(presetTens), .presetUnits(presetUnits),
  .minTens(minTens), .minUnits(minUnits), .secTens(secTens), .secUnits(secUnits),
  .isZero(isZero)
);

// File: tb/bcd_countdown_chain_bench.sv
module bcd_countdown_chain_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst, tickEn, loadMin, clearSec;
  logic [3:0] presetTens, presetUnits;
  logic [3:0] minTens, minUnits, secTens, secUnits;
  logic isZero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_countdown_chain u_bcd_countdown_chain (
    .clk(clk), .rst(rst), .tickEn(tickEn), .loadMin(loadMin), .clearSec(clearSec),
    .presetTens(presetTens), .presetUnits(presetUnits),
    .minTens(minTens), .minUnits(minUnits), .secTens(secTens), .secUnits(secUnits),
    .isZero(isZero)
  );

  // {req[4], load, clear, tick, presetT[4], presetU[4], expMT, expMU, expST, expSU, expZ}
  localparam logic [31:0] VEC [NV] = '{
    {4'd5,  1'b1,1'b0,1'b0, 4'd1,4'd2, 4'd1,4'd2,4'd0,4'd0, 1'b0}, // R5 load 12
    {4'd2,  1'b0,1'b0,1'b1, 4'd0,4'd0, 4'd1,4'd1,4'd5,4'd9, 1'b0}, // R2 00->59 borrow
    {4'd1,  1'b0,1'b0,1'b1, 4'd0,4'd0, 4'd1,4'd1,4'd5,4'd8, 1'b0}, // R1 plain step
    {4'd8,  1'b0,1'b0,1'b0, 4'd0,4'd0, 4'd1,4'd1,4'd5,4'd8, 1'b0}, // R8 idle
    {4'd6,  1'b0,1'b1,1'b0, 4'd0,4'd0, 4'd1,4'd1,4'd0,4'd0, 1'b0}, // R6 clear
    {4'd3,  1'b0,1'b0,1'b1, 4'd0,4'd0, 4'd1,4'd0,4'd5,4'd9, 1'b0}, // R3 minute borrow
    {4'd5,  1'b1,1'b0,1'b1, 4'd0,4'd5, 4'd0,4'd5,4'd5,4'd8, 1'b0}, // R5 load beats tick
    {4'd6,  1'b0,1'b1,1'b1, 4'd0,4'd0, 4'd0,4'd5,4'd0,4'd0, 1'b0}, // R6 clear beats tick
    {4'd3,  1'b0,1'b0,1'b1, 4'd0,4'd0, 4'd0,4'd4,4'd5,4'd9, 1'b0}, // R3
    {4'd5,  1'b1,1'b0,1'b0, 4'd1,4'd0, 4'd1,4'd0,4'd5,4'd9, 1'b0}, // R5 load 10
    {4'd6,  1'b0,1'b1,1'b0, 4'd0,4'd0, 4'd1,4'd0,4'd0,4'd0, 1'b0}, // R6
    {4'd4,  1'b0,1'b0,1'b1, 4'd0,4'd0, 4'd0,4'd9,4'd5,4'd9, 1'b0}, // R4 tens borrow
    {4'd7,  1'b1,1'b1,1'b0, 4'd0,4'd0, 4'd0,4'd0,4'd0,4'd0, 1'b1}, // R7 all zero
    {4'd4,  1'b0,1'b0,1'b1, 4'd0,4'd0, 4'd9,4'd9,4'd5,4'd9, 1'b0}, // R4 full underflow
    {4'd10, 1'b1,1'b0,1'b0, 4'hA,4'hC, 4'd9,4'd9,4'd5,4'd9, 1'b0}, // R10 clamp
    {4'd5,  1'b1,1'b0,1'b0, 4'd0,4'd0, 4'd0,4'd0,4'd5,4'd9, 1'b0}  // R5 load 00
  };

  task automatic check(input int req, input logic [3:0] mt, mu, st, su, input logic z);
    checks++;
    if (minTens !== mt || minUnits !== mu || secTens !== st || secUnits !== su || isZero !== z) begin
      fails++;
      $display("FAIL R%0d: got %0d%0d:%0d%0d z=%0b expected %0d%0d:%0d%0d z=%0b",
               req, minTens, minUnits, secTens, secUnits, isZero, mt, mu, st, su, z);
    end
  endtask

  task automatic step(input logic ld, cl, tk, input logic [3:0] pt, pu);
    loadMin = ld; clearSec = cl; tickEn = tk; presetTens = pt; presetUnits = pu;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; tickEn = 1'b0; loadMin = 1'b0; clearSec = 1'b0;
    presetTens = '0; presetUnits = '0;
    @(negedge clk); @(negedge clk);
    check(9, 4'd0, 4'd0, 4'd0, 4'd0, 1'b1); // R9 reset state
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][27], VEC[v][26], VEC[v][25], VEC[v][24:21], VEC[v][20:17]);
      check(int'(VEC[v][31:28]), VEC[v][16:13], VEC[v][12:9], VEC[v][8:5], VEC[v][4:1], VEC[v][0]);
    end

    // R1 R2: walk seconds 59 down to 01 at 00 minutes
    for (int k = 1; k <= 58; k++) begin
      int n;
      n = 59 - k;
      step(1'b0, 1'b0, 1'b1, 4'd0, 4'd0);
      check(((n % 10) == 9) ? 2 : 1, 4'd0, 4'd0, 4'(n / 10), 4'(n % 10), 1'b0);
    end
    step(1'b0, 1'b0, 1'b1, 4'd0, 4'd0);
    check(7, 4'd0, 4'd0, 4'd0, 4'd0, 1'b1); // R7 reaches zero

    // R9 reset overrides load and tick
    step(1'b1, 1'b0, 1'b0, 4'd3, 4'd4);
    step(1'b0, 1'b0, 1'b1, 4'd0, 4'd0);
    check(3, 4'd3, 4'd3, 4'd5, 4'd9, 1'b0); // R3
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b1, 4'd7, 4'd7);
    check(9, 4'd0, 4'd0, 4'd0, 4'd0, 1'b1); // R9
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule